// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Timed Refresh

This block connects a simple synchronous request port to a DRAM whose row and column addresses share one set of pins. Each host request carries a full word address, which the controller splits into a row part and a column part. The row part goes out first, with the row strobe asserted. After a programmable delay the column part follows, with the column strobe asserted. The write strobe is low only while a write column cycle runs. All strobes are active low.

An interval timer raises a refresh request. The controller answers it with a burst of refresh cycles in which the column strobe falls first. The row strobe is then pulsed a set number of times while the column strobe stays low, and the DRAM's own counter supplies each row. Between host accesses the controller leaves the last row open. A later access to that row needs only a new column cycle. The row is closed when a request targets another row, when the bus has been idle too long, or before a refresh. All electrical timing is expressed as whole clock cycles.

Top module: `dram_ctl`

## Requirements
- R1: While reset is high and in the cycle after it falls, the row, column and write strobes are high, `req_ready` is high and `rsp_valid` is low.
- R2: When the row strobe falls with the column strobe high, `dram_addr` carries the row part of the request address, which is the upper ROW_W bits of `req_addr`. When the column strobe later falls with the row strobe low, `dram_addr` carries the column part, which is the lower COL_W bits.
- R3: A write drives the write strobe low during its column cycle, and the word driven on `dram_dq_out` is the request's write data. A later read of the same address returns that word.
- R4: A read returns its data on `rsp_rdata` with `rsp_valid` high for exactly one cycle. `req_ready` is low from the cycle after a request is accepted until the access completes.
- R5: Consecutive requests to the row that is already open cause no new row activation; only the column strobe is cycled for each of them.
- R6: A request to a row other than the open one raises the row strobe, which stays high for at least T_RP cycles before the new row is activated.
- R7: If the bus stays idle for more than IDLE_LIMIT cycles while a row is open, the row strobe is raised. Within the first few idle cycles the row stays open.
- R8: A refresh burst lowers the column strobe while the row strobe is high, then pulses the row strobe exactly REF_ROWS times with the column strobe held low. It then raises the column strobe. A burst performs no row activation.
- R9: When the controller is idle, the starts of successive refresh bursts are exactly REF_INTERVAL cycles apart.
- R10: A refresh that becomes due while a row is open closes that row first, and the row strobe is high for at least T_RP cycles before the refresh column strobe falls. While the burst runs, `req_ready` is low. A request that waits through the burst must activate its row again afterwards.
- R11: For an activation followed by an access, the column strobe falls exactly T_RCD cycles after the row strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on a cycle where both this and req_valid are high |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Write data to the DRAM |
| dram_dq_oe | output | 1 | High while the controller drives the data pins |
| dram_dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The bench builds the controller with 4-bit rows and columns and 8-bit data. It uses T_RCD=2, T_CAS=2, T_RP=3, a refresh interval of 600 cycles, 4 rows per burst and an idle limit of 20. The short interval lets several bursts happen within one run, so their spacing can be measured exactly. The idle limit is short enough to watch a row close on its own, and long enough that a row opened shortly before a refresh is still open when that refresh falls due. A behavioural DRAM model in the bench latches the row and column from the strobe edges, stores the written data, and counts activations and refresh pulses separately.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting, row may be open
    ST_ACT,    // row strobe low, counting row-to-column delay
    ST_COL,    // column strobe low, counting column latency
    ST_PRE,    // row strobe high, precharge before reopen or idle
    ST_RCAS,   // refresh: column strobe low first
    ST_RRAS,   // refresh: row strobe pulse low
    ST_RPRE    // refresh: row strobe high between pulses
  } ctl_state_t;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LIM = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt == LIM) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) pending <= 1'b0;
    end
  end

  // R9: the burst can only be retired while one is owed
  assert_ack_pending_R9: assert property (@(posedge clk) disable iff (rst)
    ack |-> pending);
endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
  parameter int ROW_W      = 10,
  parameter int IDLE_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic             close,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] row_in,
  input  logic             busy,
  output logic             is_open,
  output logic             hit,
  output logic             idle_expired
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] ILIM = IW'(IDLE_LIMIT);

  logic [ROW_W-1:0] open_row;
  logic [IW-1:0]    idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (close) begin
      is_open <= 1'b0;
    end else if (open_set) begin
      is_open  <= 1'b1;
      open_row <= set_row;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || busy || !is_open) idle_cnt <= '0;
    else if (idle_cnt != ILIM)   idle_cnt <= idle_cnt + 1'b1;
  end

  assign hit          = is_open && (open_row == row_in);
  assign idle_expired = is_open && (idle_cnt == ILIM);

  // R7: an expiry is only reported after a quiet stretch with no activity
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    idle_expired |-> $past(!busy));
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 6250,
  parameter int REF_ROWS     = 8,
  parameter int IDLE_LIMIT   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic [DATA_W-1:0]        dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_in
);
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX  = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_CAS > T_RP) ? T_CAS : T_RP);
  localparam int CW    = $clog2(TMAX + 1);
  localparam int RW    = $clog2(REF_ROWS + 1);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_CAS = CW'(T_CAS - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(REF_ROWS - 1);

  ctl_state_t       state;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    ref_rows;
  logic             pend_act;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic             lat_write;

  logic ref_pend, ref_ack;
  logic row_open, row_hit, idle_exp;
  logic open_set, row_close;

  wire [ROW_W-1:0] in_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] in_col = req_addr[COL_W-1:0];
  wire             cnt_done = (cnt == '0);

  assign ref_ack   = (state == ST_RPRE) && cnt_done && (ref_rows == LAST_ROW);
  assign open_set  = (state == ST_ACT) && cnt_done;
  assign row_close = (state == ST_PRE) && cnt_done;
  assign req_ready = (state == ST_IDLE) && !ref_pend && !idle_exp;

  dram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
  );

  dram_row_track #(.ROW_W(ROW_W), .IDLE_LIMIT(IDLE_LIMIT)) u_rows (
    .clk(clk), .rst(rst), .open_set(open_set), .close(row_close),
    .set_row(lat_row), .row_in(in_row), .busy(state != ST_IDLE),
    .is_open(row_open), .hit(row_hit), .idle_expired(idle_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ref_rows    <= '0;
      pend_act    <= 1'b0;
      lat_row     <= '0;
      lat_col     <= '0;
      lat_write   <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!cnt_done) cnt <= cnt - 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              dram_ras_n <= 1'b1; cnt <= LD_RP; pend_act <= 1'b0; state <= ST_PRE;
            end else begin
              dram_cas_n <= 1'b0; state <= ST_RCAS;
            end
          end else if (idle_exp) begin
            dram_ras_n <= 1'b1; cnt <= LD_RP; pend_act <= 1'b0; state <= ST_PRE;
          end else if (req_valid) begin
            lat_row     <= in_row;
            lat_col     <= in_col;
            lat_write   <= req_write;
            dram_dq_out <= req_wdata;
            if (row_hit) begin
              dram_addr  <= PIN_W'(in_col);
              dram_cas_n <= 1'b0;
              dram_we_n  <= !req_write;
              dram_dq_oe <= req_write;
              cnt        <= LD_CAS;
              state      <= ST_COL;
            end else if (row_open) begin
              dram_ras_n <= 1'b1; cnt <= LD_RP; pend_act <= 1'b1; state <= ST_PRE;
            end else begin
              dram_addr  <= PIN_W'(in_row);
              dram_ras_n <= 1'b0; cnt <= LD_RCD; state <= ST_ACT;
            end
          end
        end
        ST_PRE: if (cnt_done) begin
          if (pend_act) begin
            dram_addr  <= PIN_W'(lat_row);
            dram_ras_n <= 1'b0; cnt <= LD_RCD; state <= ST_ACT;
          end else begin
            state <= ST_IDLE;
          end
          pend_act <= 1'b0;
        end
        ST_ACT: if (cnt_done) begin
          dram_addr  <= PIN_W'(lat_col);
          dram_cas_n <= 1'b0;
          dram_we_n  <= !lat_write;
          dram_dq_oe <= lat_write;
          cnt        <= LD_CAS;
          state      <= ST_COL;
        end
        ST_COL: if (cnt_done) begin
          if (!lat_write) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dram_dq_in;
          end
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          state      <= ST_IDLE;
        end
        ST_RCAS: begin
          dram_ras_n <= 1'b0; cnt <= LD_RCD; state <= ST_RRAS;
        end
        ST_RRAS: if (cnt_done) begin
          dram_ras_n <= 1'b1; cnt <= LD_RP; state <= ST_RPRE;
        end
        ST_RPRE: if (cnt_done) begin
          if (ref_rows == LAST_ROW) begin
            ref_rows   <= '0;
            dram_cas_n <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            ref_rows   <= ref_rows + 1'b1;
            dram_ras_n <= 1'b0; cnt <= LD_RCD; state <= ST_RRAS;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe-spacing counters used by the checks below
  localparam int SW = $clog2(TMAX + 2);
  localparam logic [SW-1:0] SAT = SW'(TMAX + 1);
  logic [SW-1:0] ras_hi_cnt, ras_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_hi_cnt <= SAT;
      ras_lo_cnt <= '0;
    end else if (dram_ras_n) begin
      ras_lo_cnt <= '0;
      if (ras_hi_cnt != SAT) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end else begin
      ras_hi_cnt <= '0;
      if (ras_lo_cnt != SAT) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    end
  end

  // R6: every row strobe fall follows at least T_RP high cycles
  assert_precharge_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= SW'(T_RP)));

  // R11: a column cycle never starts sooner than T_RCD after the row strobe
  assert_rcd_R11: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_lo_cnt >= SW'(T_RCD)));

  // R10: column-first strobing only happens for an owed refresh
  assert_cbr_owed_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && dram_ras_n) |-> ref_pend);

  // R4: read response is a single-cycle pulse
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R3: write strobe only inside an opened column cycle
  assert_we_in_col_R3: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> (!dram_cas_n && !dram_ras_n && dram_dq_oe));
endmodule

// File: tb/sim_dram_ctl.sv
module sim_dram_ctl;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3;
  localparam int REF_INTERVAL = 600, REF_ROWS = 4, IDLE_LIMIT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [3:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

  always #10 clk = ~clk;

  dram_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL),
    .REF_ROWS(REF_ROWS), .IDLE_LIMIT(IDLE_LIMIT)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural DRAM model and strobe monitor, sampled 5 ns after each rising edge
  logic [DATA_W-1:0] mem [0:255];
  logic [ROW_W-1:0] cur_row = '0, act_row = '0;
  logic [COL_W-1:0] cur_col = '0;
  int cyc = 0, acts = 0, cas_cols = 0, ref_pulses = 0, ref_starts = 0;
  int act_cyc = 0, ras_rise_cyc = 0, last_pre_len = 0, last_rcd = 0;
  int ref_start = 0, prev_ref_start = 0, ref_pre_gap = 0, burst_cnt = 0, last_burst = 0;
  int written = 0;
  bit in_ref = 0, prev_ras = 1, prev_cas = 1;
  assign dram_dq_in = mem[{cur_row, cur_col}];

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always begin
    @(posedge clk); #5;
    cyc++;
    if (prev_ras && !dram_ras_n) begin
      if (!dram_cas_n) begin ref_pulses++; burst_cnt++; end
      else begin
        acts++; cur_row = dram_addr; act_row = dram_addr;
        act_cyc = cyc; last_pre_len = cyc - ras_rise_cyc;
      end
    end
    if (!prev_ras && dram_ras_n) ras_rise_cyc = cyc;
    if (prev_cas && !dram_cas_n) begin
      if (!dram_ras_n) begin
        cur_col = dram_addr; cas_cols++; last_rcd = cyc - act_cyc;
        if (!dram_we_n) begin mem[{cur_row, cur_col}] = dram_dq_out; written = dram_dq_out; end
      end else begin
        ref_starts++; prev_ref_start = ref_start; ref_start = cyc;
        ref_pre_gap = cyc - ras_rise_cyc; burst_cnt = 0; in_ref = 1;
      end
    end
    if (!prev_cas && dram_cas_n && in_ref) begin in_ref = 0; last_burst = burst_cnt; end
    prev_ras = dram_ras_n; prev_cas = dram_cas_n;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  // One host access; returns read data, whether ready dropped, and response pulse width
  task automatic access(input bit wr, input int row, input int col, input int data,
                        output int q, output bit busy_seen, output bit pulse_ok);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 8'(row * 16 + col); req_wdata = 8'(data);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    busy_seen = !req_ready;
    q = 0; pulse_ok = 1;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      q = rsp_rdata;
      @(negedge clk);
      pulse_ok = !rsp_valid;
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic wait_burst_end();
    int n0 = ref_starts;
    while (ref_starts == n0 || in_ref) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(req_ready && !rsp_valid, "R1 handshake", {req_ready, rsp_valid}, 2);
    rst = 0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && req_ready && !rsp_valid, "R1 after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, req_ready, rsp_valid}, 5'b11110);
  endtask

  task automatic t_basic();
    int q; bit b, p;
    access(1, 2, 5, 8'hA5, q, b, p);
    chk(act_row == 2, "R2 row address", act_row, 2);
    chk(cur_col == 5, "R2 column address", cur_col, 5);
    chk(last_rcd == T_RCD, "R11 row-to-column delay", last_rcd, T_RCD);
    chk(written == 8'hA5 && b, "R3 write strobe data", written, 8'hA5);
    access(0, 2, 5, 0, q, b, p);
    chk(q == 8'hA5, "R3 readback", q, 8'hA5);
    chk(b, "R4 ready low while busy", b, 1);
    chk(p, "R4 single-cycle response", p, 1);
  endtask

  task automatic t_page();
    int q; bit b, p;
    int a0 = acts, c0 = cas_cols;
    access(1, 2, 6, 8'h3C, q, b, p);
    access(0, 2, 6, 0, q, b, p);
    chk(q == 8'h3C, "R5 page read data", q, 8'h3C);
    access(0, 2, 5, 0, q, b, p);
    chk(q == 8'hA5, "R5 page read second column", q, 8'hA5);
    chk(acts == a0, "R5 no new activation", acts - a0, 0);
    chk(cas_cols == c0 + 3, "R5 column cycles", cas_cols - c0, 3);
  endtask

  task automatic t_switch();
    int q; bit b, p;
    int a0 = acts;
    access(1, 9, 1, 8'h77, q, b, p);
    chk(acts == a0 + 1 && act_row == 9, "R6 new row activated", act_row, 9);
    chk(last_pre_len >= T_RP, "R6 precharge length", last_pre_len, T_RP);
    access(0, 2, 6, 0, q, b, p);
    chk(q == 8'h3C && last_pre_len >= T_RP, "R6 return to first row", q, 8'h3C);
  endtask

  task automatic t_idle();
    int q; bit b, p;
    int a0;
    access(0, 9, 1, 0, q, b, p);
    repeat (4) @(negedge clk);
    chk(!dram_ras_n, "R7 row still open", dram_ras_n, 0);
    repeat (40) @(negedge clk);
    chk(dram_ras_n, "R7 row closed after idle", dram_ras_n, 1);
    a0 = acts;
    access(0, 9, 1, 0, q, b, p);
    chk(acts == a0 + 1 && q == 8'h77, "R7 reopen after idle close", acts - a0, 1);
  endtask

  task automatic t_refresh();
    int a0;
    wait_burst_end();
    chk(last_burst == REF_ROWS, "R8 pulses per burst", last_burst, REF_ROWS);
    a0 = acts;
    wait_burst_end();
    chk(acts == a0, "R8 burst makes no activation", acts - a0, 0);
    chk(last_burst == REF_ROWS, "R8 second burst length", last_burst, REF_ROWS);
    chk(ref_start - prev_ref_start == REF_INTERVAL, "R9 burst spacing",
        ref_start - prev_ref_start, REF_INTERVAL);
  endtask

  task automatic t_priority();
    int q; bit b, p;
    int a0, open_cyc;
    bit ready_seen;
    access(1, 4, 7, 8'h5A, q, b, p);
    while (cyc < ref_start + REF_INTERVAL - 15) @(negedge clk);
    access(0, 4, 7, 0, q, b, p);
    open_cyc = act_cyc;
    chk(q == 8'h5A && !dram_ras_n, "R10 row open before refresh", dram_ras_n, 0);
    while (!in_ref) @(negedge clk);
    chk(ras_rise_cyc > open_cyc, "R10 open row closed first", ras_rise_cyc, open_cyc + 1);
    chk(ref_pre_gap >= T_RP, "R10 precharge before refresh", ref_pre_gap, T_RP);
    req_valid = 1; req_write = 1; req_addr = 8'h4B; req_wdata = 8'hC3;
    a0 = acts; ready_seen = 0;
    while (in_ref) begin
      if (req_ready) ready_seen = 1;
      @(negedge clk);
    end
    chk(!ready_seen, "R10 ready low during burst", ready_seen, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    chk(acts == a0 + 1, "R10 reactivation after refresh", acts - a0, 1);
    access(0, 4, 11, 0, q, b, p);
    chk(q == 8'hC3, "R10 held write landed", q, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    wait_burst_end();
    t_basic();
    t_page();
    t_switch();
    t_idle();
    t_refresh();
    t_priority();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule